// File: doc/BRIEF.md
# Column-Latch Page Flash Write Controller

This block sits between a processor's data-space write port and a page-organised nonvolatile array. While the latch-mapping input `map_en` is high, every write the processor makes is captured into a 128-byte column latch instead of reaching ordinary data memory. Each captured byte sets its own valid flag, and all of them must belong to one page: the page number is taken from the upper address bits, and the low 7 bits pick the latch byte.

A pulse on `launch` starts a timed sequence. The sequence takes the valid bytes in rising offset order. For each one it first erases that array location and then programs it. Locations that were never loaded are not touched, so a single byte, a whole page or any scattered subset of a page can be rewritten without a separate page or block erase. `busy` stays high for the whole sequence. When the sequence ends, `done` pulses and the latch is empty again.

A boot-map input moves the top 2 KiB of the address space (F800h and above) to a secondary array region. The `arr_boot` strobe qualifier tells the array which region to use.

Top module: `colpage_flash_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `load_err`, `arr_erase`, `arr_we` and `arr_boot` are 0, and `wr_ready` is 1.
- R2: A write handshake (`wr_valid` && `wr_ready`) loads the latch only while `map_en` is 1. Writes accepted with `map_en` at 0 are dropped, so a later launch has nothing to program.
- R3: `wr_ready` is low exactly while `busy` is high. A write offered during that time is not taken and must be held by the source. Nothing is loaded while busy.
- R4: The first byte loaded into an empty latch fixes the page as `wr_addr[15:7]`. A later load whose `wr_addr[15:7]` differs is ignored, and `load_err` pulses for one cycle, the cycle after the handshake.
- R5: Loading the same offset (`wr_addr[6:0]`) twice before launch keeps the value written last.
- R6: For each valid byte, the array sees `arr_erase` for ERASE_CYC cycles and then `arr_we` for PROG_CYC cycles, both at the same `arr_addr` = {page, offset}. Bytes are processed in ascending offset order. The two strobes are never high together.
- R7: After the sequence, every loaded location holds its latest latch value, and every other location of the page and of the other region keeps its earlier contents.
- R8: For N valid bytes, `busy` goes high the cycle after `launch` and stays high for exactly N*(ERASE_CYC+PROG_CYC) cycles. `done` pulses as it falls. All valid flags are then clear, so an immediate second launch has nothing to program.
- R9: A `launch` pulse while `busy` is high is ignored. It neither lengthens the sequence nor produces a second `done`.
- R10: A launch with no valid bytes raises no strobe, leaves `busy` low and pulses `done` the cycle after `launch`.
- R11: During a strobe, `arr_boot` is 1 exactly when `boot_map` is 1 and `arr_addr[15:11]` is all ones (F800h to FFFFh).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_en | input | 1 | Routes data-space writes into the column latch |
| boot_map | input | 1 | Maps the secondary region onto F800h to FFFFh |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | Write address: page in upper bits, latch offset in low 7 bits |
| wr_data | input | 8 | Write data byte |
| launch | input | 1 | One-cycle pulse that starts erase/program |
| busy | output | 1 | Programming sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| load_err | output | 1 | One-cycle pulse when a load was refused for a page mismatch |
| arr_erase | output | 1 | Erase strobe for arr_addr |
| arr_we | output | 1 | Program strobe for arr_addr with arr_wdata |
| arr_boot | output | 1 | Selects the secondary region for the current strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Byte to program |

## Verification
The hardest situation to reach from the ports is a load or a launch that arrives while a sequence is running. It is the only way to show that the latch is sealed (R3) and that the sequencer ignores a new start (R9). The bench produces it by holding a mapped write and pulsing `launch` in the middle of a long sequence. It then fires an empty launch to show that no byte got in. Scattered random subsets of random pages, with repeated offsets and foreign-page writes mixed in, cover ordering, partial-page preservation and the boot-region decode.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ERASE = 2'd1,
    SQ_PROG  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cl_latch_buf.sv
module cl_latch_buf #(
  parameter int OFF_W  = 7,
  parameter int PAGE_W = 9,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic [PAGE_W-1:0]       ld_page,
  input  logic [OFF_W-1:0]        ld_off,
  input  logic [DATA_W-1:0]       ld_data,
  input  logic                    clr_en,
  input  logic [OFF_W-1:0]        clr_off,
  input  logic [OFF_W-1:0]        rd_off,
  output logic [(1<<OFF_W)-1:0]   valid,
  output logic [PAGE_W-1:0]       page,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    ld_err
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              any_v;
  logic              accept;
  logic              reject;

  assign any_v   = |valid;
  assign accept  = ld_en && (!any_v || (ld_page == page));
  assign reject  = ld_en && any_v && (ld_page != page);
  assign rd_data = mem[rd_off];

  always_ff @(posedge clk) begin
    if (accept) mem[ld_off] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= '0;
      page   <= '0;
      ld_err <= 1'b0;
    end else begin
      ld_err <= reject;
      if (ld_en && !any_v) page <= ld_page;
      if (accept) valid[ld_off] <= 1'b1;
      if (clr_en) valid[clr_off] <= 1'b0;
    end
  end
endmodule

// File: rtl/cl_low_find.sv
module cl_low_find #(
  parameter int N  = 128,
  parameter int IW = 7
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  assign found = |vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cl_seq.sv
module cl_seq
  import flash_pkg::*;
#(
  parameter int OFF_W     = 7,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             nxt_found,
  input  logic [OFF_W-1:0] nxt_idx,
  output logic             busy,
  output logic             done,
  output logic             erase_on,
  output logic             prog_on,
  output logic             clr_en,
  output logic [OFF_W-1:0] ptr
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] E_LAST = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PROG_CYC - 1);

  seq_state_e       st;
  logic [CW-1:0]    cnt;

  assign busy     = (st != SQ_IDLE);
  assign erase_on = (st == SQ_ERASE);
  assign prog_on  = (st == SQ_PROG);
  assign clr_en   = prog_on && (cnt == P_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      cnt  <= '0;
      ptr  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (launch) begin
            if (nxt_found) begin
              st  <= SQ_ERASE;
              ptr <= nxt_idx;
              cnt <= '0;
            end else begin
              done <= 1'b1;
            end
          end
        end
        SQ_ERASE: begin
          if (cnt == E_LAST) begin
            st  <= SQ_PROG;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_PROG: begin
          if (cnt == P_LAST) begin
            cnt <= '0;
            if (nxt_found) begin
              st  <= SQ_ERASE;
              ptr <= nxt_idx;
            end else begin
              st   <= SQ_IDLE;
              done <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/colpage_flash_ctrl.sv
module colpage_flash_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 7,
  parameter int DATA_W    = 8,
  parameter int BOOT_W    = 5,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_en,
  input  logic              boot_map,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              launch,
  output logic              busy,
  output logic              done,
  output logic              load_err,
  output logic              arr_erase,
  output logic              arr_we,
  output logic              arr_boot,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << OFF_W;

  logic [DEPTH-1:0]  valid;
  logic [DEPTH-1:0]  rest_vec;
  logic [DEPTH-1:0]  find_vec;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  ptr;
  logic [OFF_W-1:0]  nxt_idx;
  logic              nxt_found;
  logic              clr_en;
  logic              ld_en;

  assign wr_ready = !busy;
  assign ld_en    = wr_valid && wr_ready && map_en;

  always_comb begin
    rest_vec      = valid;
    rest_vec[ptr] = 1'b0;
  end
  assign find_vec = busy ? rest_vec : valid;

  cl_latch_buf #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_page (wr_addr[ADDR_W-1:OFF_W]),
    .ld_off  (wr_addr[OFF_W-1:0]),
    .ld_data (wr_data),
    .clr_en  (clr_en),
    .clr_off (ptr),
    .rd_off  (ptr),
    .valid   (valid),
    .page    (page),
    .rd_data (arr_wdata),
    .ld_err  (load_err)
  );

  cl_low_find #(.N(DEPTH), .IW(OFF_W)) u_find (
    .vec   (find_vec),
    .found (nxt_found),
    .idx   (nxt_idx)
  );

  cl_seq #(.OFF_W(OFF_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .nxt_found (nxt_found),
    .nxt_idx   (nxt_idx),
    .busy      (busy),
    .done      (done),
    .erase_on  (arr_erase),
    .prog_on   (arr_we),
    .clr_en    (clr_en),
    .ptr       (ptr)
  );

  assign arr_addr = {page, ptr};
  assign arr_boot = (arr_erase || arr_we) && boot_map && (&page[PAGE_W-1 -: BOOT_W]);
endmodule

// File: rtl/colpage_flash_chk.sv
module colpage_flash_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              map_en,
  input logic              boot_map,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              busy,
  input logic              done,
  input logic              load_err,
  input logic              arr_erase,
  input logic              arr_we,
  input logic              arr_boot,
  input logic [ADDR_W-1:0] arr_addr
);
  p_ready_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_erase && arr_we));

  p_strobe_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_erase || arr_we) |-> busy);

  p_erase_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_we) |-> ($past(arr_erase) && arr_addr == $past(arr_addr)));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !arr_we && !arr_erase));

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> $past(wr_valid && wr_ready && map_en));

  p_boot_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_boot |-> (boot_map && (arr_erase || arr_we)));
endmodule

bind colpage_flash_ctrl colpage_flash_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .map_en    (map_en),
  .boot_map  (boot_map),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .busy      (busy),
  .done      (done),
  .load_err  (load_err),
  .arr_erase (arr_erase),
  .arr_we    (arr_we),
  .arr_boot  (arr_boot),
  .arr_addr  (arr_addr)
);

// File: tb/sim_colpage_flash_ctrl.sv
`timescale 1ns/1ps
module sim_colpage_flash_ctrl;
  localparam int ADDR_W = 16;
  localparam int E_CYC  = 4;
  localparam int P_CYC  = 6;
  localparam int SEQ    = E_CYC + P_CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_en = 1'b0, boot_map = 1'b0, wr_valid = 1'b0, launch = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, busy, done, load_err, arr_erase, arr_we, arr_boot;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0] arr_wdata;

  always #4 clk = ~clk;

  colpage_flash_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYC(E_CYC), .PROG_CYC(P_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .boot_map(boot_map),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .launch(launch), .busy(busy), .done(done), .load_err(load_err),
    .arr_erase(arr_erase), .arr_we(arr_we), .arr_boot(arr_boot),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // array model (actual) and expected image, background pattern elsewhere
  logic [7:0] am_main [int];
  logic [7:0] am_boot [int];
  logic [7:0] ex_main [int];
  logic [7:0] ex_boot [int];

  function automatic logic [7:0] bg(input int a, input bit b);
    return 8'(a) ^ 8'(a >> 8) ^ (b ? 8'h5A : 8'h00);
  endfunction
  function automatic logic [7:0] rd_act(input bit b, input int a);
    if (b) return am_boot.exists(a) ? am_boot[a] : bg(a, 1'b1);
    return am_main.exists(a) ? am_main[a] : bg(a, 1'b0);
  endfunction
  function automatic logic [7:0] rd_exp(input bit b, input int a);
    if (b) return ex_boot.exists(a) ? ex_boot[a] : bg(a, 1'b1);
    return ex_main.exists(a) ? ex_main[a] : bg(a, 1'b0);
  endfunction

  int busy_cnt = 0;
  bit done_flag = 1'b0;
  int erase_q[$];
  logic prev_erase = 1'b0;

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (done) done_flag = 1'b1;
    if (arr_erase && !prev_erase) erase_q.push_back(int'(arr_addr[6:0]));
    prev_erase = arr_erase;
    if (arr_erase) begin
      if (arr_boot) am_boot[int'(arr_addr)] = 8'hFF; else am_main[int'(arr_addr)] = 8'hFF;
    end
    if (arr_we) begin
      if (arr_boot) am_boot[int'(arr_addr)] = arr_wdata; else am_main[int'(arr_addr)] = arr_wdata;
    end
  end

  // bench shadow of latch contents
  logic [7:0] sh_d [128];
  bit sh_v [128];
  int sh_n = 0;
  int sh_page = 0;

  task automatic do_load(input int addr, input logic [7:0] d, input bit m);
    int pg, off;
    bit exp_err;
    pg = addr >> 7; off = addr & 127;
    exp_err = m && (sh_n > 0) && (pg != sh_page);
    @(negedge clk);
    wr_valid = 1'b1; map_en = m; wr_addr = ADDR_W'(addr); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; map_en = 1'b0;
    chk(load_err == exp_err, "R4 load_err", int'(load_err), int'(exp_err));
    if (m && !exp_err) begin
      if (sh_n == 0) sh_page = pg;
      if (!sh_v[off]) sh_n++;
      sh_v[off] = 1'b1; sh_d[off] = d;
    end
  endtask

  task automatic do_launch(input bit bm, input bit poke_busy);
    int n_exp, idx, pg;
    bit breg;
    n_exp = sh_n;
    pg = sh_page;
    breg = bm && ((pg >> 4) == 31);
    boot_map = bm;
    erase_q.delete();
    busy_cnt = 0;
    done_flag = 1'b0;
    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
    if (n_exp == 0) begin
      chk(done == 1'b1, "R10 done after empty launch", int'(done), 1);
      chk(busy == 1'b0, "R10 busy stays low", int'(busy), 0);
    end
    if (poke_busy && n_exp > 0) begin
      repeat (3) @(negedge clk);
      chk(wr_ready == 1'b0, "R3 ready low while busy", int'(wr_ready), 0);
      wr_valid = 1'b1; map_en = 1'b1; wr_addr = ADDR_W'(pg * 128 + 7); wr_data = 8'hC3;
      launch = 1'b1;
      @(negedge clk); launch = 1'b0;
      @(negedge clk); wr_valid = 1'b0; map_en = 1'b0;
    end
    for (int w = 0; w < 3000 && !done_flag; w++) @(negedge clk);
    chk(done_flag, "R8 done seen", int'(done_flag), 1);
    chk(busy_cnt == n_exp * SEQ, "R8 busy length", busy_cnt, n_exp * SEQ);
    chk(erase_q.size() == n_exp, "R6 erase count", erase_q.size(), n_exp);
    idx = 0;
    for (int o = 0; o < 128; o++) begin
      if (sh_v[o]) begin
        if (idx < erase_q.size())
          chk(erase_q[idx] == o, "R6 ascending order", erase_q[idx], o);
        idx++;
        if (breg) ex_boot[pg * 128 + o] = sh_d[o]; else ex_main[pg * 128 + o] = sh_d[o];
      end
    end
    begin
      int bad, first_a;
      bad = 0; first_a = -1;
      for (int o = 0; o < 128; o++) begin
        int a;
        a = pg * 128 + o;
        if (rd_act(1'b0, a) != rd_exp(1'b0, a) || rd_act(1'b1, a) != rd_exp(1'b1, a)) begin
          bad++;
          if (first_a < 0) first_a = a;
        end
      end
      chk(bad == 0, "R7 R11 page image", first_a, -1);
    end
    for (int o = 0; o < 128; o++) sh_v[o] = 1'b0;
    sh_n = 0;
    if (poke_busy) begin
      done_flag = 1'b0;
      repeat (20) @(negedge clk);
      chk(!done_flag, "R9 no second done", int'(done_flag), 0);
      chk(busy_cnt == n_exp * SEQ, "R9 length unchanged", busy_cnt, n_exp * SEQ);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1A2B;
    void'($urandom(seed));
    for (int o = 0; o < 128; o++) sh_v[o] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !load_err && !arr_erase && !arr_we && !arr_boot, "R1 outputs idle",
        int'({busy, done, load_err, arr_erase, arr_we, arr_boot}), 0);
    chk(wr_ready == 1'b1, "R1 ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: unmapped writes are dropped
    do_load(16'h1234, 8'h11, 1'b0);
    do_load(16'h1235, 8'h22, 1'b0);
    do_launch(1'b0, 1'b0);

    // R10: empty launch straight away
    do_launch(1'b0, 1'b0);

    // R5 and R4: rewrite and foreign page
    do_load(16'h0405, 8'hA1, 1'b1);
    do_load(16'h0405, 8'hB2, 1'b1);
    do_load(16'h0410, 8'h7E, 1'b1);
    do_load(16'h2410, 8'h99, 1'b1);
    do_launch(1'b0, 1'b0);
    chk(rd_act(1'b0, 16'h0405) == 8'hB2, "R5 last value kept", int'(rd_act(1'b0, 16'h0405)), 8'hB2);
    chk(rd_act(1'b0, 16'h2410) == bg(16'h2410, 1'b0), "R4 foreign byte untouched",
        int'(rd_act(1'b0, 16'h2410)), int'(bg(16'h2410, 1'b0)));

    // R8: second launch after completion is empty
    do_launch(1'b0, 1'b0);

    // R11: boot region with and without mapping
    do_load(16'hF880, 8'h3C, 1'b1);
    do_load(16'hF8FF, 8'h4D, 1'b1);
    do_launch(1'b1, 1'b0);
    do_load(16'hF881, 8'h5E, 1'b1);
    do_launch(1'b0, 1'b0);
    do_load(16'hF7FF, 8'h6F, 1'b1);
    do_launch(1'b1, 1'b0);

    // R3 and R9: load and launch during busy, then verify latch stayed empty
    for (int o = 0; o < 40; o += 3) do_load(16'h3300 + o, 8'(o * 5 + 1), 1'b1);
    do_launch(1'b0, 1'b1);
    do_launch(1'b0, 1'b0);

    // full page
    for (int o = 0; o < 128; o++) do_load(16'h5A00 + o, 8'(o ^ 8'hA5), 1'b1);
    do_launch(1'b0, 1'b0);

    // random rounds
    for (int r = 0; r < 30; r++) begin
      int pg, n;
      bit bm;
      pg = ($urandom % 4 == 0) ? (496 + $urandom % 16) : ($urandom % 512);
      bm = 1'($urandom % 2);
      n  = 1 + $urandom % 16;
      for (int k = 0; k < n; k++) begin
        int off;
        off = $urandom % 128;
        if ($urandom % 6 == 0)
          do_load(((pg + 1 + $urandom % 100) % 512) * 128 + off, 8'($urandom), 1'b1);
        else
          do_load(pg * 128 + off, 8'($urandom), ($urandom % 8) != 0);
      end
      do_launch(bm, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule